// File: doc/BRIEF.md
# Soft-Value Block Double Buffer

This block sits between a symbol demapper and a block decoder. Each symbol delivers three soft values (LLRs), which arrive together as one packed word. The block packs them into one of two memory banks. Each bank holds exactly one coded block: 2688 symbols, or 8064 soft values, by default. When a bank has received its last symbol, the block pulses a block-ready strobe that says which bank is ready. Writing then moves on to the other bank.

The decoder answers the strobe with a start pulse on the next cycle. The block then streams the finished bank back one symbol word per cycle, with an address and a done flag, while the demapper keeps writing the other bank. A bank becomes writable again only once its read has ended. If the bank due for writing is still full or still being read, a stall output tells the demapper that its symbols are being refused.

Top module: `llr_pp_buf`

## Requirements
- R1: While reset is low and right after it, stall_o, blk_valid_o, rd_valid_o and rd_done_o are 0, and the first completed block is reported on bank 0.
- R2: A symbol is accepted in every cycle where sym_valid_i is 1 and stall_o is 0. It is stored at the next address of the current write bank. sym_llr_i packs soft value k in bits [k*LLR_W +: LLR_W], and the word is returned unchanged.
- R3: In the cycle after the SYMS_PER_BLK-th symbol of a block is accepted, blk_valid_o is 1 for exactly one cycle. In that cycle blk_bank_o names the filled bank. Banks fill in the order 0, 1, 0, 1, and so on.
- R4: If rd_start_i is sampled 1 while no read is running and the oldest unread bank is full, the first word of that bank appears on rd_data_o two cycles later with rd_valid_o = 1. The remaining words follow on consecutive cycles with rd_addr_o counting 0 to SYMS_PER_BLK-1. Banks are read in the order they filled.
- R5: rd_done_o is 1 only together with the word at address SYMS_PER_BLK-1.
- R6: rd_start_i has no effect when no full bank is waiting or while a read is running. In those cases no extra words appear and the running stream is not disturbed.
- R7: stall_o is 1 while the current write bank is full or being read. Symbols offered while stall_o is 1 are discarded and never appear in any block.
- R8: stall_o falls in the same cycle that rd_done_o reports the end of the read that was blocking the write bank.
- R9: Writing one bank and reading the other proceed at the same time, with no stall while the write bank is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | Symbol strobe from the demapper |
| sym_llr_i | input | LLR_PER_SYM*LLR_W | Packed soft values of one symbol |
| stall_o | output | 1 | Write bank unavailable; input refused |
| blk_valid_o | output | 1 | One-cycle pulse: a bank is full |
| blk_bank_o | output | 1 | Bank that has just filled |
| rd_start_i | input | 1 | Decoder request to read the next full bank |
| rd_valid_o | output | 1 | rd_data_o holds a word |
| rd_addr_o | output | $clog2(SYMS_PER_BLK) | Symbol index of rd_data_o |
| rd_data_o | output | LLR_PER_SYM*LLR_W | Packed soft values read back |
| rd_done_o | output | 1 | Last word of the bank |

## Verification
The bench holds off the decoder until both banks are full. The demapper then keeps offering altered symbols, and the bench checks that they are refused. A design that released a bank early, or that ignored stall, would overwrite unread soft values, and the scoreboard would see wrong words. Start pulses are sent while nothing is full and again in the middle of a read while the other bank is full. A design that honoured either pulse would restart the address count, emit extra words, or read a bank out of order. The bench also checks the two-cycle start latency, that the done flag comes with the last address only, and that stall drops in the done cycle. Each of these catches an off-by-one in the read pointer or in the bank release.

// File: rtl/llr_pp_pkg.sv
package llr_pp_pkg;
  typedef enum logic [1:0] {
    BANK_FREE = 2'd0,
    BANK_FULL = 2'd1,
    BANK_READ = 2'd2
  } bank_st_e;
  localparam int unsigned NUM_BANKS = 2;
endpackage

// File: rtl/llr_pp_bank.sv
module llr_pp_bank #(
  parameter int unsigned DW    = 18,
  parameter int unsigned DEPTH = 2688,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/llr_pp_ctrl.sv
module llr_pp_ctrl
  import llr_pp_pkg::*;
#(
  parameter int unsigned DEPTH = 2688,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sym_valid_i,
  input  logic          rd_start_i,
  output logic          stall_o,
  output logic          wr_en_o,
  output logic          wr_bank_o,
  output logic [AW-1:0] wr_addr_o,
  output logic          blk_valid_o,
  output logic          blk_bank_o,
  output logic          rd_en_o,
  output logic          rd_bank_o,
  output logic [AW-1:0] rd_addr_o,
  output logic          out_valid_o,
  output logic [AW-1:0] out_addr_o,
  output logic          out_done_o,
  output logic          out_bank_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  bank_st_e      st_q [NUM_BANKS];
  logic          wr_bank_q, rd_bank_q, reading_q;
  logic [AW-1:0] waddr_q, raddr_q;
  logic          wr_last, rd_go, rd_last;

  assign stall_o   = (st_q[wr_bank_q] != BANK_FREE);
  assign wr_en_o   = sym_valid_i && !stall_o;
  assign wr_bank_o = wr_bank_q;
  assign wr_addr_o = waddr_q;
  assign wr_last   = wr_en_o && (waddr_q == LAST);
  // start honoured only when idle and the oldest bank is complete
  assign rd_go     = rd_start_i && !reading_q && (st_q[rd_bank_q] == BANK_FULL);
  assign rd_last   = reading_q && (raddr_q == LAST);
  assign rd_en_o   = reading_q;
  assign rd_bank_o = rd_bank_q;
  assign rd_addr_o = raddr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int b = 0; b < NUM_BANKS; b++) st_q[b] <= BANK_FREE;
      wr_bank_q   <= 1'b0;
      rd_bank_q   <= 1'b0;
      reading_q   <= 1'b0;
      waddr_q     <= '0;
      raddr_q     <= '0;
      blk_valid_o <= 1'b0;
      blk_bank_o  <= 1'b0;
      out_valid_o <= 1'b0;
      out_addr_o  <= '0;
      out_done_o  <= 1'b0;
      out_bank_o  <= 1'b0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (wr_last && wr_bank_q == 1'(b))      st_q[b] <= BANK_FULL;
        else if (rd_go && rd_bank_q == 1'(b))   st_q[b] <= BANK_READ;
        else if (rd_last && rd_bank_q == 1'(b)) st_q[b] <= BANK_FREE;
      end
      if (wr_en_o) begin
        waddr_q <= wr_last ? '0 : waddr_q + 1'b1;
        if (wr_last) wr_bank_q <= ~wr_bank_q;
      end
      blk_valid_o <= wr_last;
      if (wr_last) blk_bank_o <= wr_bank_q;
      if (rd_go) begin
        reading_q <= 1'b1;
        raddr_q   <= '0;
      end else if (reading_q) begin
        raddr_q <= raddr_q + 1'b1;
        if (rd_last) begin
          reading_q <= 1'b0;
          rd_bank_q <= ~rd_bank_q;
        end
      end
      // output stage aligned with the one-cycle bank read
      out_valid_o <= reading_q;
      out_addr_o  <= raddr_q;
      out_done_o  <= rd_last;
      out_bank_o  <= rd_bank_q;
    end
  end

  assert_blk_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |=> !blk_valid_o);
  assert_blk_bank_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk_valid_o |-> st_q[blk_bank_o] == BANK_FULL);
  assert_no_overwrite_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sym_valid_i && st_q[wr_bank_q] != BANK_FREE) |=> $stable(waddr_q));
  assert_seq_addr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_done_o) |=> out_valid_o && out_addr_o == AW'($past(out_addr_o) + 1'b1));
  assert_done_last_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_done_o |-> out_valid_o && out_addr_o == LAST);
  assert_one_reader_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({st_q[0] == BANK_READ, st_q[1] == BANK_READ}) <= 1);
  assert_release_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_done_o && $past(stall_o) && wr_bank_q == out_bank_o) |-> !stall_o);
endmodule

// File: rtl/llr_pp_buf.sv
module llr_pp_buf
  import llr_pp_pkg::*;
#(
  parameter int unsigned LLR_W        = 6,
  parameter int unsigned LLR_PER_SYM  = 3,
  parameter int unsigned SYMS_PER_BLK = 2688,
  localparam int unsigned SYM_W       = LLR_W * LLR_PER_SYM,
  localparam int unsigned AW          = $clog2(SYMS_PER_BLK)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sym_valid_i,
  input  logic [SYM_W-1:0] sym_llr_i,
  output logic             stall_o,
  output logic             blk_valid_o,
  output logic             blk_bank_o,
  input  logic             rd_start_i,
  output logic             rd_valid_o,
  output logic [AW-1:0]    rd_addr_o,
  output logic [SYM_W-1:0] rd_data_o,
  output logic             rd_done_o
);
  logic          wr_en, wr_bank, rd_en, rd_bank, out_bank;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [SYM_W-1:0] bank_rd [NUM_BANKS];

  llr_pp_ctrl #(.DEPTH(SYMS_PER_BLK)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sym_valid_i (sym_valid_i),
    .rd_start_i  (rd_start_i),
    .stall_o     (stall_o),
    .wr_en_o     (wr_en),
    .wr_bank_o   (wr_bank),
    .wr_addr_o   (wr_addr),
    .blk_valid_o (blk_valid_o),
    .blk_bank_o  (blk_bank_o),
    .rd_en_o     (rd_en),
    .rd_bank_o   (rd_bank),
    .rd_addr_o   (rd_addr),
    .out_valid_o (rd_valid_o),
    .out_addr_o  (rd_addr_o),
    .out_done_o  (rd_done_o),
    .out_bank_o  (out_bank)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    llr_pp_bank #(.DW(SYM_W), .DEPTH(SYMS_PER_BLK)) u_bank (
      .clk_i   (clk_i),
      .we_i    (wr_en && wr_bank == 1'(b)),
      .waddr_i (wr_addr),
      .wdata_i (sym_llr_i),
      .re_i    (rd_en && rd_bank == 1'(b)),
      .raddr_i (rd_addr),
      .rdata_o (bank_rd[b])
    );
  end

  assign rd_data_o = bank_rd[out_bank];
endmodule

// File: tb/llr_pp_buf_tb_top.sv
`timescale 1ns/1ps
module llr_pp_buf_tb_top;
  localparam int LW = 6, NS = 6, SW = 18, AW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic sym_valid = 1'b0, rd_start = 1'b0;
  logic [SW-1:0] sym_llr = '0;
  logic stall, blk_valid, blk_bank, rd_valid, rd_done;
  logic [AW-1:0] rd_addr;
  logic [SW-1:0] rd_data;

  llr_pp_buf #(.LLR_W(LW), .LLR_PER_SYM(3), .SYMS_PER_BLK(NS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sym_valid_i(sym_valid), .sym_llr_i(sym_llr),
    .stall_o(stall), .blk_valid_o(blk_valid), .blk_bank_o(blk_bank),
    .rd_start_i(rd_start), .rd_valid_o(rd_valid), .rd_addr_o(rd_addr),
    .rd_data_o(rd_data), .rd_done_o(rd_done));

  int errors = 0, checks = 0;
  logic [SW-1:0] sq[$];
  bit busy [2];
  bit wr_m = 0, rd_m = 0, exp_blk = 0, exp_blk_bank = 0;
  bit hold = 0, reading_m = 0, poke_req = 0, real_start = 0, finished = 0;
  int wcnt = 0, pend = 0, cyc = 0, exp_first = 0, ridx = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] pat(input int i);
    logic [31:0] v;
    v = 32'(i) * 32'h9E3779B1 ^ 32'h0005A5A5;
    return v[SW-1:0];
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // driver: offers one symbol, pushes it to the scoreboard once accepted
  task automatic send_sym(input logic [SW-1:0] d);
    while (busy[wr_m]) begin
      sym_valid = 1'b1;
      sym_llr   = ~d;
      chk(stall == 1'b1, "R7 stall while write bank busy", 32'(stall), 1);
      @(negedge clk);
    end
    sym_valid = 1'b1;
    sym_llr   = d;
    chk(stall == 1'b0, "R9 no stall with free write bank", 32'(stall), 0);
    @(posedge clk);
    sq.push_back(d);
    wcnt++;
    if (wcnt == NS) begin
      wcnt = 0;
      busy[wr_m] = 1'b1;
      exp_blk = 1'b1;
      exp_blk_bank = wr_m;
      wr_m = ~wr_m;
    end
    @(negedge clk);
    sym_valid = 1'b0;
  endtask

  // consumer: starts the read on the cycle after each ready pulse
  initial forever begin
    @(negedge clk);
    rd_start = 1'b0;
    real_start = 1'b0;
    if (poke_req) begin
      rd_start = 1'b1;
      poke_req = 0;
    end else if (rst_n && pend > 0 && !hold && !reading_m) begin
      rd_start = 1'b1;
      real_start = 1'b1;
      pend--;
      reading_m = 1'b1;
    end
  end

  // monitor
  initial forever begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      cyc++;
      chk(blk_valid == exp_blk, "R3 blk_valid pulse", 32'(blk_valid), 32'(exp_blk));
      if (blk_valid && exp_blk)
        chk(blk_bank == exp_blk_bank, "R3 blk_bank", 32'(blk_bank), 32'(exp_blk_bank));
      if (blk_valid) pend++;
      exp_blk = 0;
      if (rd_start && real_start) exp_first = cyc + 1;
      if (rd_valid) begin
        if (!reading_m || sq.size() == 0) begin
          chk(1'b0, "R6 word without accepted start", 32'(rd_addr), 0);
        end else begin
          logic [SW-1:0] e;
          e = sq.pop_front();
          chk(rd_data == e, "R2 R4 read data", 32'(rd_data), 32'(e));
          chk(rd_addr == AW'(ridx), "R4 read address", 32'(rd_addr), 32'(ridx));
          if (ridx == 0) chk(cyc == exp_first, "R4 start latency", 32'(cyc), 32'(exp_first));
          chk(rd_done == (ridx == NS - 1), "R5 done with last word", 32'(rd_done), 32'(ridx == NS - 1));
          if (ridx == NS - 1) begin
            chk(stall == 1'b0 || busy[wr_m ^ 1'b0] == 1'b1 && wr_m != rd_m, "R8 stall released with done",
                32'(stall), 0);
            busy[rd_m] = 1'b0;
            rd_m = ~rd_m;
            reading_m = 1'b0;
            ridx = 0;
          end else ridx++;
        end
      end else begin
        chk(rd_done == 1'b0, "R5 done without data", 32'(rd_done), 0);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(stall == 0 && blk_valid == 0 && rd_valid == 0 && rd_done == 0, "R1 outputs in reset",
        {28'd0, stall, blk_valid, rd_valid, rd_done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(stall == 0 && blk_valid == 0 && rd_valid == 0 && rd_done == 0, "R1 outputs after reset",
        {28'd0, stall, blk_valid, rd_valid, rd_done}, 0);

    // start with nothing full
    poke_req = 1;
    repeat (6) @(negedge clk);
    chk(rd_valid == 0, "R6 start with empty banks ignored", 32'(rd_valid), 0);

    // phase A: three blocks, consumer immediate, idle gaps
    for (int i = 0; i < 3 * NS; i++) begin
      send_sym(pat(i));
      if (i % 4 == 3) @(negedge clk);
    end
    repeat (3 * NS) @(negedge clk);

    // phase B: hold decoder, fill both banks, third block must stall
    hold = 1;
    fork
      begin
        for (int i = 100; i < 100 + 3 * NS; i++) send_sym(pat(i));
      end
      begin
        repeat (5 * NS) @(negedge clk);
        hold = 0;
        wait (reading_m);
        repeat (3) @(negedge clk);
        poke_req = 1;
      end
    join

    // phase C: continuous stream, overlap of write and read
    for (int i = 200; i < 200 + 4 * NS; i++) send_sym(pat(i));
    repeat (6 * NS) @(negedge clk);
    chk(sq.size() == 0, "R9 all accepted symbols read back", 32'(sq.size()), 0);
    chk(pend == 0 && !reading_m, "R4 every ready bank was read", 32'(pend), 0);
    finish_run();
  end
endmodule